// File: doc/BRIEF.md
# Single-Port SRAM Wrapper with Deep-Sleep and Shutdown Modes

This block wraps a small register-array store so that it behaves like a single-port SRAM macro. It offers an active-low select, an active-low write strobe and an active-low per-bit write mask. Reads are registered. The access port is a one-cycle command strobe with no back-pressure: any selected cycle is taken in the same clock, so the block has no valid/ready handshake. A test-select input switches every access signal over to a second, dedicated self-test port.

Two power-mode inputs sit in front of the store. Deep sleep refuses every access and keeps the contents. Shutdown refuses every access and destroys the contents; the destroyed words are modelled by a fixed poison pattern. When both inputs are high, shutdown wins. Each mode input has its own status flag, which follows that input only after the input has been steady for a set number of clock edges. A power sequencer can wait on these flags. An access tried during either low-power mode sets a sticky error bit.

Top module: `sram_pm_wrap`

## Requirements
- R1: On a write cycle (port selected, write strobe low, both power inputs low), each data bit whose mask bit is 0 takes the write data, and each bit whose mask bit is 1 keeps its old value.
- R2: On a read cycle (port selected, write strobe high, both power inputs low), `rdata` shows the addressed word after the next rising clock edge.
- R3: `rdata` keeps its previous value after any cycle that is a write, a deselected cycle, or a cycle with `dslp` or `sd` high.
- R4: While `dslp` is high and `sd` is low, reads and writes are refused and every stored word is kept unchanged.
- R5: While `sd` is high, every access is refused. Every stored word reads back as the poison pattern (the parameter byte, 0xA5 by default, repeated) once shutdown has been seen on a clock edge.
- R6: When `sd` and `dslp` are both high, shutdown behaviour applies: contents are lost and read back as the poison pattern.
- R7: `sleep_done` follows `dslp` and `off_done` follows `sd`. Each flag changes on the SETTLE-th consecutive rising edge that samples its input at the new level (default 4). A shorter pulse restarts the count.
- R8: While `tst_sel` is 1, only the `tst_*` signals reach the store and the `fn_*` signals have no effect. While `tst_sel` is 0, the reverse holds.
- R9: `acc_err` becomes 1 after any selected cycle with `dslp` or `sd` high. It then stays 1 until reset.
- R10: During reset, `rdata` is 0, both status flags are 0 and `acc_err` is 0. Reset does not alter the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fn_cs_n | input | 1 | Functional port select, active low |
| fn_we_n | input | 1 | Functional port write strobe, active low |
| fn_addr | input | AW | Functional port word address |
| fn_wdata | input | DW | Functional port write data |
| fn_mask_n | input | DW | Functional port bit mask, 0 = write that bit |
| tst_sel | input | 1 | 1 = self-test port drives the store |
| tst_cs_n | input | 1 | Test port select, active low |
| tst_we_n | input | 1 | Test port write strobe, active low |
| tst_addr | input | AW | Test port word address |
| tst_wdata | input | DW | Test port write data |
| tst_mask_n | input | DW | Test port bit mask, 0 = write that bit |
| dslp | input | 1 | Deep-sleep request |
| sd | input | 1 | Shutdown request |
| rdata | output | DW | Registered read data |
| sleep_done | output | 1 | Deep-sleep status flag |
| off_done | output | 1 | Shutdown status flag |
| acc_err | output | 1 | Sticky error: access tried in a low-power mode |

## Verification
The assertions assume that every input is known and changes only away from the rising edge. They also assume that the power inputs are treated as synchronous levels, so their comparisons against the array state on the next edge are well defined. The stimulus drives every input on the falling edge. It fills the whole array before any random traffic starts, so every read has a defined expected value. Throughout the random phase, the port that is not selected carries random, often selected, commands, which shows that it has no effect.

// File: rtl/sram_pm_pkg.sv
package sram_pm_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_OFF    = 2'd2
  } pm_mode_e;

  // shutdown outranks deep sleep
  function automatic pm_mode_e pm_decode(input logic sd_i, input logic ds_i);
    if (sd_i) return PM_OFF;
    if (ds_i) return PM_SLEEP;
    return PM_ACTIVE;
  endfunction
endpackage

// File: rtl/sram_pm_portsel.sv
module sram_pm_portsel #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          sel,
  input  logic          a_cs_n,
  input  logic          a_we_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic [DW-1:0] a_mask_n,
  input  logic          b_cs_n,
  input  logic          b_we_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  input  logic [DW-1:0] b_mask_n,
  output logic          o_cs_n,
  output logic          o_we_n,
  output logic [AW-1:0] o_addr,
  output logic [DW-1:0] o_wdata,
  output logic [DW-1:0] o_mask_n
);
  always_comb begin
    if (sel) begin
      o_cs_n   = b_cs_n;
      o_we_n   = b_we_n;
      o_addr   = b_addr;
      o_wdata  = b_wdata;
      o_mask_n = b_mask_n;
    end else begin
      o_cs_n   = a_cs_n;
      o_we_n   = a_we_n;
      o_addr   = a_addr;
      o_wdata  = a_wdata;
      o_mask_n = a_mask_n;
    end
  end
endmodule

// File: rtl/sram_pm_settle.sv
module sram_pm_settle #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic flag
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (lvl_in == flag) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      flag <= lvl_in;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(lvl_in));
  // R7
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> !$past(lvl_in));
endmodule

// File: rtl/sram_pm_array.sv
module sram_pm_array
  import sram_pm_pkg::*;
#(
  parameter int          AW          = 4,
  parameter int          DW          = 8,
  parameter logic [7:0]  POISON_BYTE = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pm_mode_e      mode,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mask_n,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [DW-1:0] fill_poison(input logic [7:0] b);
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++) p[i] = b[i % 8];
    return p;
  endfunction

  localparam logic [DW-1:0] POISON = fill_poison(POISON_BYTE);

  logic [DW-1:0] mem [DEPTH];
  logic          wr_go;
  logic          rd_go;

  assign wr_go = (mode == PM_ACTIVE) && !cs_n && !we_n;
  assign rd_go = (mode == PM_ACTIVE) && !cs_n &&  we_n;

  always_ff @(posedge clk) begin
    if (mode == PM_OFF) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= POISON;
    end else if (wr_go) begin
      mem[addr] <= (mem[addr] & mask_n) | (wdata & ~mask_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_go) rdata <= mem[addr];
  end

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !we_n || mode != PM_ACTIVE) |=> $stable(rdata));
  // R2
  rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_ACTIVE && !cs_n && we_n) |=> rdata == $past(mem[addr]));
  // R4
  sleep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP) |=> mem[$past(addr)] == $past(mem[addr]));
  // R5
  off_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_OFF) |=> mem[$past(addr)] == POISON);
endmodule

// File: rtl/sram_pm_wrap.sv
module sram_pm_wrap
  import sram_pm_pkg::*;
#(
  parameter int         AW          = 4,
  parameter int         DW          = 8,
  parameter int         SETTLE      = 4,
  parameter logic [7:0] POISON_BYTE = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fn_cs_n,
  input  logic          fn_we_n,
  input  logic [AW-1:0] fn_addr,
  input  logic [DW-1:0] fn_wdata,
  input  logic [DW-1:0] fn_mask_n,
  input  logic          tst_sel,
  input  logic          tst_cs_n,
  input  logic          tst_we_n,
  input  logic [AW-1:0] tst_addr,
  input  logic [DW-1:0] tst_wdata,
  input  logic [DW-1:0] tst_mask_n,
  input  logic          dslp,
  input  logic          sd,
  output logic [DW-1:0] rdata,
  output logic          sleep_done,
  output logic          off_done,
  output logic          acc_err
);
  logic          s_cs_n;
  logic          s_we_n;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic [DW-1:0] s_mask_n;
  pm_mode_e      mode;
  logic [1:0]    lvl;
  logic [1:0]    flg;

  assign mode = pm_decode(sd, dslp);

  sram_pm_portsel #(.AW(AW), .DW(DW)) u_sel (
    .sel(tst_sel),
    .a_cs_n(fn_cs_n), .a_we_n(fn_we_n), .a_addr(fn_addr),
    .a_wdata(fn_wdata), .a_mask_n(fn_mask_n),
    .b_cs_n(tst_cs_n), .b_we_n(tst_we_n), .b_addr(tst_addr),
    .b_wdata(tst_wdata), .b_mask_n(tst_mask_n),
    .o_cs_n(s_cs_n), .o_we_n(s_we_n), .o_addr(s_addr),
    .o_wdata(s_wdata), .o_mask_n(s_mask_n)
  );

  sram_pm_array #(.AW(AW), .DW(DW), .POISON_BYTE(POISON_BYTE)) u_arr (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .cs_n(s_cs_n), .we_n(s_we_n), .addr(s_addr),
    .wdata(s_wdata), .mask_n(s_mask_n), .rdata(rdata)
  );

  assign lvl = {sd, dslp};

  for (genvar g = 0; g < 2; g++) begin : g_settle
    sram_pm_settle #(.SETTLE(SETTLE)) u_settle (
      .clk(clk), .rst_n(rst_n), .lvl_in(lvl[g]), .flag(flg[g])
    );
  end

  assign sleep_done = flg[0];
  assign off_done   = flg[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             acc_err <= 1'b0;
    else if (!s_cs_n && mode != PM_ACTIVE)  acc_err <= 1'b1;
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> acc_err);
  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_cs_n && (dslp || sd)) |=> acc_err);
endmodule

// File: tb/test_sram_pm_wrap.sv
module test_sram_pm_wrap;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int SETTLE = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] POISON = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fn_cs_n = 1'b1, fn_we_n = 1'b1;
  logic [AW-1:0] fn_addr = '0;
  logic [DW-1:0] fn_wdata = '0, fn_mask_n = '1;
  logic          tst_sel = 1'b0;
  logic          tst_cs_n = 1'b1, tst_we_n = 1'b1;
  logic [AW-1:0] tst_addr = '0;
  logic [DW-1:0] tst_wdata = '0, tst_mask_n = '1;
  logic          dslp = 1'b0, sd = 1'b0;
  logic [DW-1:0] rdata;
  logic          sleep_done, off_done, acc_err;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] mem_m [DEPTH];
  logic [DW-1:0] rd_m  = '0;
  logic          err_m = 1'b0;

  sram_pm_wrap #(.AW(AW), .DW(DW), .SETTLE(SETTLE)) i_sram_pm_wrap (
    .clk(clk), .rst_n(rst_n),
    .fn_cs_n(fn_cs_n), .fn_we_n(fn_we_n), .fn_addr(fn_addr),
    .fn_wdata(fn_wdata), .fn_mask_n(fn_mask_n),
    .tst_sel(tst_sel), .tst_cs_n(tst_cs_n), .tst_we_n(tst_we_n),
    .tst_addr(tst_addr), .tst_wdata(tst_wdata), .tst_mask_n(tst_mask_n),
    .dslp(dslp), .sd(sd), .rdata(rdata),
    .sleep_done(sleep_done), .off_done(off_done), .acc_err(acc_err)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one access cycle: drive now (falling edge), update model, check at next falling edge
  task automatic op(input bit tsel, input bit cs_n, input bit we_n,
                    input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [DW-1:0] m, input bit junk);
    tst_sel = tsel;
    if (tsel) begin
      tst_cs_n = cs_n; tst_we_n = we_n; tst_addr = a; tst_wdata = d; tst_mask_n = m;
      fn_cs_n = junk ? 1'($urandom) : 1'b1; fn_we_n = 1'($urandom);
      fn_addr = AW'($urandom); fn_wdata = DW'($urandom); fn_mask_n = DW'($urandom);
    end else begin
      fn_cs_n = cs_n; fn_we_n = we_n; fn_addr = a; fn_wdata = d; fn_mask_n = m;
      tst_cs_n = junk ? 1'($urandom) : 1'b1; tst_we_n = 1'($urandom);
      tst_addr = AW'($urandom); tst_wdata = DW'($urandom); tst_mask_n = DW'($urandom);
    end
    @(negedge clk);
    if (!cs_n && (sd || dslp)) err_m = 1'b1;
    if (sd) begin
      for (int i = 0; i < DEPTH; i++) mem_m[i] = POISON;
    end else if (!dslp && !cs_n) begin
      if (!we_n) mem_m[a] = (mem_m[a] & m) | (d & ~m);
      else       rd_m = mem_m[a];
    end
    chk("R1 R2 R3 R8 rdata", 32'(rdata), 32'(rd_m));
    chk("R9 acc_err", 32'(acc_err), 32'(err_m));
  endtask

  task automatic idle();
    op(1'b0, 1'b1, 1'b1, '0, '0, '1, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rd_m = '0; err_m = 1'b0;
    chk("R10 rdata in reset", 32'(rdata), 0);
    chk("R10 sleep_done in reset", 32'(sleep_done), 0);
    chk("R10 off_done in reset", 32'(off_done), 0);
    chk("R10 acc_err in reset", 32'(acc_err), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    @(negedge clk);
    do_reset();

    // fill array with full-mask writes
    for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b0, 1'b0, AW'(i), DW'(i * 17 + 3), '0, 1'b0);

    // R1 R2 directed
    op(1'b0, 1'b0, 1'b0, 4'd3, 8'hFF, 8'h00, 1'b0);
    op(1'b0, 1'b0, 1'b1, 4'd3, 8'h00, 8'h00, 1'b0);
    chk("R2 read after full write", 32'(rdata), 32'h00FF);
    op(1'b0, 1'b0, 1'b0, 4'd3, 8'h00, 8'hF0, 1'b0);
    op(1'b0, 1'b0, 1'b1, 4'd3, 8'h00, 8'h00, 1'b0);
    chk("R1 masked write low nibble", 32'(rdata), 32'h00F0);
    // R3 hold on write and deselect
    op(1'b0, 1'b0, 1'b0, 4'd5, 8'h11, 8'h00, 1'b0);
    chk("R3 hold after write", 32'(rdata), 32'h00F0);
    idle();
    chk("R3 hold after deselect", 32'(rdata), 32'h00F0);

    // R8 random traffic, both ports, unselected port noisy
    for (int n = 0; n < 400; n++)
      op(1'($urandom), 1'(($urandom % 4) == 0), 1'($urandom), AW'($urandom),
         DW'($urandom), DW'($urandom), 1'b1);

    op(1'b0, 1'b0, 1'b0, 4'd3, 8'h3C, 8'h00, 1'b0);

    // R7 R4 deep sleep
    dslp = 1'b1;
    for (int k = 1; k <= SETTLE; k++) begin
      idle();
      chk("R7 sleep_done rise", 32'(sleep_done), 32'(k == SETTLE));
    end
    op(1'b0, 1'b0, 1'b0, 4'd3, 8'h5A, 8'h00, 1'b0);
    chk("R9 err after sleep access", 32'(acc_err), 1);
    op(1'b1, 1'b0, 1'b1, 4'd3, 8'h00, 8'h00, 1'b0);
    chk("R3 hold in sleep", 32'(rdata), 32'(rd_m));
    dslp = 1'b0;
    for (int k = 1; k <= SETTLE; k++) begin
      idle();
      chk("R7 sleep_done fall", 32'(sleep_done), 32'(k != SETTLE));
    end
    op(1'b0, 1'b0, 1'b1, 4'd3, 8'h00, 8'h00, 1'b0);
    chk("R4 contents kept", 32'(rdata), 32'h003C);
    // R7 short pulse restarts count
    dslp = 1'b1;
    idle(); idle();
    dslp = 1'b0;
    idle();
    dslp = 1'b1;
    idle(); idle(); idle();
    chk("R7 short pulse no flag", 32'(sleep_done), 0);
    idle();
    chk("R7 flag after full run", 32'(sleep_done), 1);
    dslp = 1'b0;
    for (int k = 0; k < SETTLE; k++) idle();
    chk("R9 sticky before reset", 32'(acc_err), 1);
    do_reset();
    idle();
    chk("R9 cleared by reset", 32'(acc_err), 0);
    op(1'b0, 1'b0, 1'b1, 4'd3, 8'h00, 8'h00, 1'b0);
    chk("R10 reset kept contents", 32'(rdata), 32'h003C);

    // R5 shutdown alone
    sd = 1'b1;
    for (int k = 1; k <= SETTLE; k++) begin
      idle();
      chk("R7 off_done rise", 32'(off_done), 32'(k == SETTLE));
    end
    op(1'b0, 1'b0, 1'b0, 4'd7, 8'h00, 8'h00, 1'b0);
    sd = 1'b0;
    for (int k = 1; k <= SETTLE; k++) begin
      idle();
      chk("R7 off_done fall", 32'(off_done), 32'(k != SETTLE));
    end
    op(1'b0, 1'b0, 1'b1, 4'd3, 8'h00, 8'h00, 1'b0);
    chk("R5 poison after shutdown", 32'(rdata), 32'(POISON));
    op(1'b0, 1'b0, 1'b1, 4'd7, 8'h00, 8'h00, 1'b0);
    chk("R5 blocked write, poison", 32'(rdata), 32'(POISON));

    // R6 both asserted
    op(1'b0, 1'b0, 1'b0, 4'd9, 8'h66, 8'h00, 1'b0);
    sd = 1'b1; dslp = 1'b1;
    idle(); idle();
    sd = 1'b0; dslp = 1'b0;
    idle();
    op(1'b0, 1'b0, 1'b1, 4'd9, 8'h00, 8'h00, 1'b0);
    chk("R6 shutdown wins over sleep", 32'(rdata), 32'(POISON));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule